// File: doc/BRIEF.md
# Processor Interrupt Control Unit

This block is the interrupt-control core of a small processor. It keeps the processor status word, whose bit 0 is the global interrupt-enable flag. It also keeps a saved copy of that word, a per-source enable mask and a per-source pending bitmap that follows up to eight request lines. At each instruction boundary the fetch logic raises a strobe. While that strobe is high, the block says whether an interrupt must be taken. The condition is that the global enable is set and at least one pending source is also enabled.

The fetch logic answers with an entry strobe when it starts the service routine, and with a return strobe at return-from-interrupt. On entry the block copies the status word into the saved register and clears the enable flag, so the handler runs without being interrupted again. On return the block copies the saved word back, which restores the earlier enable setting.

The four control registers are reached through a move port that exchanges values with the general-purpose registers. The port has a register select, a write strobe with write data, and a combinational read path. Saving the program counter and fetching the vector are handled outside this block.

Top module: `irqc_top`

## Requirements
- R1: After reset, all four control registers (status, saved status, enable mask, pending) read 0 and `take_irq` is 0.
- R2: On a cycle with `enter_stb` high, the saved-status register receives the status value held in that cycle.
- R3: On a cycle with `enter_stb` high, status bit 0 (the global enable) is cleared to 0, and all other status bits keep their values.
- R4: On a cycle with `leave_stb` high and `enter_stb` low, the status register is loaded from the saved-status register.
- R5: `take_irq` is 1 exactly when `boundary_stb` is 1, status bit 0 is 1, and the bitwise AND of pending and enable mask is non-zero. It is 0 in every other cycle, including when status bit 0 is 0.
- R6: A source whose enable-mask bit is 0 never causes `take_irq`, however long its request stays high.
- R7: Each pending bit equals the level its request line had one clock earlier. It rises and falls with the line, and only the line can clear it.
- R8: Move port select codes are: 0 = status, 1 = saved status, 2 = enable mask, 3 = pending. `mv_wr` writes `mv_wdata` into the selected register at the clock edge. `mv_rdata` shows the selected register at once, zero-extended. A write with select 3 is ignored.
- R9: `enter_stb` takes precedence over a move write to status or saved status in the same cycle, and over `leave_stb`. `leave_stb` takes precedence over a move write to status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_SRC | Level request lines, one per source |
| boundary_stb | input | 1 | Instruction boundary, evaluation point |
| take_irq | output | 1 | Interrupt must be taken now |
| enter_stb | input | 1 | Interrupt entry performed |
| leave_stb | input | 1 | Return from interrupt performed |
| mv_sel | input | 2 | Control register select |
| mv_wr | input | 1 | Move-to write strobe |
| mv_wdata | input | DW | Move-to data |
| mv_rdata | output | DW | Move-from data |

## Verification
The block has three kinds of result, each due at its own time. `take_irq` is combinational, so it is due in the same cycle as the boundary strobe. A pending bit appears one edge after its request line changes. A register write, entry or return shows on the read port after the next edge. The bench drives inputs just after a rising edge and has the monitor compare at the falling edge of the cycle the driver queued. Every expected value is therefore taken after the register it depends on has been clocked.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEL_STAT  = 2'd0,
    SEL_SAVED = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_PEND  = 2'd3
  } csr_sel_e;

  localparam int IE_POS = 0;
endpackage

// File: rtl/irqc_status_regs.sv
module irqc_status_regs #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter,
  input  logic              leave,
  input  logic              wr_stat,
  input  logic              wr_saved,
  input  logic [STAT_W-1:0] wr_val,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] saved_q
);
  import irqc_pkg::*;

  localparam logic [STAT_W-1:0] IE_CLR = ~(STAT_W'(1) << IE_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      saved_q <= '0;
    end else if (enter) begin
      saved_q <= stat_q;
      stat_q  <= stat_q & IE_CLR;
    end else begin
      if (leave)        stat_q <= saved_q;
      else if (wr_stat) stat_q <= wr_val;
      if (wr_saved)     saved_q <= wr_val;
    end
  end
endmodule

// File: rtl/irqc_source_bank.sv
module irqc_source_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             wr_mask,
  input  logic [N_SRC-1:0] wr_val,
  output logic [N_SRC-1:0] mask_q,
  output logic [N_SRC-1:0] pend_q
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        pend_q[i] <= irq_req[i];
        if (wr_mask) mask_q[i] <= wr_val[i];
      end
    end
  end
endmodule

// File: rtl/irqc_take_logic.sv
module irqc_take_logic #(
  parameter int N_SRC = 8
) (
  input  logic             boundary,
  input  logic             gie,
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] mask,
  output logic             take
);
  logic any_live;
  always_comb begin
    any_live = |(pend & mask);
    take     = boundary & gie & any_live;
  end
endmodule

// File: rtl/irqc_regport.sv
module irqc_regport #(
  parameter int N_SRC  = 8,
  parameter int STAT_W = 8,
  parameter int DW     = 32
) (
  input  logic [1:0]        sel,
  input  logic              wr,
  input  logic [STAT_W-1:0] stat,
  input  logic [STAT_W-1:0] saved,
  input  logic [N_SRC-1:0]  mask,
  input  logic [N_SRC-1:0]  pend,
  output logic              wr_stat,
  output logic              wr_saved,
  output logic              wr_mask,
  output logic [DW-1:0]     rdata
);
  import irqc_pkg::*;

  csr_sel_e s;
  always_comb begin
    s        = csr_sel_e'(sel);
    wr_stat  = wr && (s == SEL_STAT);
    wr_saved = wr && (s == SEL_SAVED);
    wr_mask  = wr && (s == SEL_MASK);
    unique case (s)
      SEL_STAT:  rdata = DW'(stat);
      SEL_SAVED: rdata = DW'(saved);
      SEL_MASK:  rdata = DW'(mask);
      default:   rdata = DW'(pend);
    endcase
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int N_SRC  = 8,
  parameter int STAT_W = 8,
  parameter int DW     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             boundary_stb,
  output logic             take_irq,
  input  logic             enter_stb,
  input  logic             leave_stb,
  input  logic [1:0]       mv_sel,
  input  logic             mv_wr,
  input  logic [DW-1:0]    mv_wdata,
  output logic [DW-1:0]    mv_rdata
);
  import irqc_pkg::*;

  logic [STAT_W-1:0] stat_q, saved_q;
  logic [N_SRC-1:0]  mask_q, pend_q;
  logic              wr_stat, wr_saved, wr_mask;

  irqc_regport #(.N_SRC(N_SRC), .STAT_W(STAT_W), .DW(DW)) u_port (
    .sel(mv_sel), .wr(mv_wr), .stat(stat_q), .saved(saved_q),
    .mask(mask_q), .pend(pend_q), .wr_stat(wr_stat),
    .wr_saved(wr_saved), .wr_mask(wr_mask), .rdata(mv_rdata)
  );

  irqc_status_regs #(.STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .enter(enter_stb), .leave(leave_stb),
    .wr_stat(wr_stat), .wr_saved(wr_saved),
    .wr_val(mv_wdata[STAT_W-1:0]), .stat_q(stat_q), .saved_q(saved_q)
  );

  irqc_source_bank #(.N_SRC(N_SRC)) u_src (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .wr_mask(wr_mask),
    .wr_val(mv_wdata[N_SRC-1:0]), .mask_q(mask_q), .pend_q(pend_q)
  );

  irqc_take_logic #(.N_SRC(N_SRC)) u_take (
    .boundary(boundary_stb), .gie(stat_q[IE_POS]), .pend(pend_q),
    .mask(mask_q), .take(take_irq)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N_SRC  = 8,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  irq_req,
  input logic              boundary_stb,
  input logic              take_irq,
  input logic              enter_stb,
  input logic              leave_stb,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] saved_q,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_SRC-1:0]  pend_q
);
  logic started;
  always_ff @(posedge clk) started <= rst_n;

  a_r2_entry_saves: assert property (@(posedge clk) disable iff (!rst_n)
    enter_stb |=> saved_q == $past(stat_q));
  a_r3_entry_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
    enter_stb |=> (!stat_q[0] && stat_q[STAT_W-1:1] == $past(stat_q[STAT_W-1:1])));
  a_r4_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (leave_stb && !enter_stb) |=> stat_q == $past(saved_q));
  a_r5_take_gated: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (boundary_stb && stat_q[0]));
  a_r6_take_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (|(pend_q & mask_q)));
  a_r7_pending_mirrors: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> pend_q == $past(irq_req));
endmodule

bind irqc_top irqc_checker #(.N_SRC(N_SRC), .STAT_W(STAT_W)) u_chk (.*);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int N = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic          boundary_stb = 1'b0;
  logic          take_irq;
  logic          enter_stb = 1'b0;
  logic          leave_stb = 1'b0;
  logic [1:0]    mv_sel = 2'd0;
  logic          mv_wr = 1'b0;
  logic [DW-1:0] mv_wdata = '0;
  logic [DW-1:0] mv_rdata;

  int checks = 0;
  int errors = 0;
  logic probe = 1'b0;
  logic done = 1'b0;

  typedef struct {
    bit          is_take;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  irqc_top #(.N_SRC(N), .STAT_W(8), .DW(DW)) u_dut (.*);

  // monitor: pops the scoreboard at the falling edge of a probed cycle
  always @(negedge clk) begin
    if (probe && sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb.pop_front();
      act = it.is_take ? {31'd0, take_irq} : mv_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    item_t it;
    step();
    mv_sel = sel;
    it.is_take = 1'b0; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    probe = 1'b1;
    step();
    probe = 1'b0;
  endtask

  task automatic chk_take(input logic exp, input string tag);
    item_t it;
    step();
    boundary_stb = 1'b1;
    it.is_take = 1'b1; it.exp = {31'd0, exp}; it.tag = tag;
    sb.push_back(it);
    probe = 1'b1;
    step();
    probe = 1'b0;
    boundary_stb = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d,
                    input logic ent, input logic lv);
    step();
    mv_sel = sel; mv_wr = 1'b1; mv_wdata = d; enter_stb = ent; leave_stb = lv;
    step();
    mv_wr = 1'b0; enter_stb = 1'b0; leave_stb = 1'b0;
  endtask

  task automatic pulse(input logic ent, input logic lv);
    step();
    enter_stb = ent; leave_stb = lv;
    step();
    enter_stb = 1'b0; leave_stb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R1 reset values
    rd(2'd0, 32'h0, "R1 status");
    rd(2'd1, 32'h0, "R1 saved");
    rd(2'd2, 32'h0, "R1 mask");
    rd(2'd3, 32'h0, "R1 pending");
    chk_take(1'b0, "R1 take idle");
    // R8 mask write/read
    wr(2'd2, 32'h05, 1'b0, 1'b0);
    rd(2'd2, 32'h05, "R8 mask write");
    wr(2'd0, 32'h01, 1'b0, 1'b0);
    rd(2'd0, 32'h01, "R8 status write");
    // R6 disabled source
    step(); irq_req = 8'h02;
    rd(2'd3, 32'h02, "R7 pending rises");
    chk_take(1'b0, "R6 masked source");
    chk_take(1'b0, "R6 masked source held");
    // R5 enabled source
    step(); irq_req = 8'h06;
    chk_take(1'b1, "R5 take enabled");
    step();
    sb.push_back('{1'b1, 32'h0, "R5 no boundary"});
    probe = 1'b1; step(); probe = 1'b0;
    wr(2'd0, 32'h00, 1'b0, 1'b0);
    chk_take(1'b0, "R5 global disable");
    // R2 R3 entry
    wr(2'd0, 32'hA1, 1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    rd(2'd0, 32'hA0, "R3 ie cleared");
    rd(2'd1, 32'hA1, "R2 saved copy");
    chk_take(1'b0, "R3 no nested take");
    // R4 return
    wr(2'd0, 32'h30, 1'b0, 1'b0);
    pulse(1'b0, 1'b1);
    rd(2'd0, 32'hA1, "R4 status restored");
    chk_take(1'b1, "R4 take after return");
    // R8 pending read-only
    wr(2'd3, 32'hFF, 1'b0, 1'b0);
    rd(2'd3, 32'h06, "R8 pending write ignored");
    // R7 falls
    step(); irq_req = 8'h00;
    rd(2'd3, 32'h00, "R7 pending falls");
    chk_take(1'b0, "R7 no take after drop");
    // R9 priorities
    wr(2'd0, 32'h41, 1'b0, 1'b0);
    wr(2'd0, 32'h77, 1'b1, 1'b0);
    rd(2'd0, 32'h40, "R9 entry beats status write");
    rd(2'd1, 32'h41, "R9 entry saved");
    wr(2'd0, 32'h10, 1'b0, 1'b1);
    rd(2'd0, 32'h41, "R9 return beats status write");
    wr(2'd1, 32'h5B, 1'b1, 1'b1);
    rd(2'd1, 32'h41, "R9 entry beats saved write and return");
    rd(2'd0, 32'h40, "R9 entry beats return");
    wr(2'd1, 32'h03, 1'b0, 1'b0);
    pulse(1'b0, 1'b1);
    rd(2'd0, 32'h03, "R8 saved write then R4 return");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule